// File: doc/BRIEF.md
# Write Burst Shape Legality Monitor

This block watches the address and data halves of a write channel without driving any handshake signal. Each time an address handshake completes it records the declared burst shape (start address, beat count field, size field and burst type) and tests that shape for legality against the width of the data bus, the 4 KB page rule for incrementing bursts, and the length and alignment rules for wrapping bursts. It then counts the accepted data beats of that burst and confirms that the last-beat marker arrives on exactly the beat that the declared length predicts.

Every violation class owns one sticky flag bit. A 3-bit code holds the class of the first violation seen since the last clear. A synchronous clear input resets both. A burst whose last-beat marker agrees with a legal but unintended length is internally consistent, so it raises nothing; catching that needs an independent model of intent elsewhere. One burst is tracked at a time: the monitor captures the next address only after the current burst's data phase has ended.

Burst type encoding on `aw_kind`: 0 fixed, 1 incrementing, 2 wrapping.

Top module: `burst_shape_monitor`

## Requirements
- R1: After reset, `err_vec` is 0 and `err_code` is 0.
- R2: A captured burst whose size field exceeds log2 of the bus width in bytes (3 for a 64-bit bus) sets `err_vec[0]`; its code is 1.
- R3: An incrementing burst whose size-aligned start offset within its 4 KB page plus the span (len+1) << size exceeds 4096 sets `err_vec[1]` (code 2); a burst ending exactly on the page boundary is legal.
- R4: A wrapping burst whose beat count (len+1) is not 2, 4, 8 or 16 sets `err_vec[2]` (code 3).
- R5: A wrapping burst whose start address is not a multiple of 1 << size sets `err_vec[3]` (code 4).
- R6: A data beat carrying the last marker at a zero-based beat index below len sets `err_vec[4]` (code 5) and ends the burst.
- R7: A data beat at zero-based index len without the last marker sets `err_vec[5]` (code 6) and ends the burst.
- R8: A data beat counts only on a clock edge where both `w_valid` and `w_ready` are high; cycles with either low change no flag and no count.
- R9: A burst with a legal shape whose last marker falls on beat len raises no flag, whether or not that length was the one intended.
- R10: Flags are sticky; `err_code` keeps the first class seen, and when several classes are detected together it takes the lowest code among them.
- R11: With `clr` high on a clock edge, `err_vec` and `err_code` are 0 after that edge, taking priority over errors detected in the same cycle.
- R12: All flags and the code update on the clock edge of the handshake or beat that reveals them, visible immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of flags and code |
| aw_valid | input | 1 | Address valid |
| aw_ready | input | 1 | Address ready |
| aw_addr | input | ADDR_W | Burst start address |
| aw_len | input | 8 | Beat count minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_kind | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping |
| w_valid | input | 1 | Data valid |
| w_ready | input | 1 | Data ready |
| w_last | input | 1 | Last-beat marker |
| err_vec | output | 6 | Sticky per-class violation flags |
| err_code | output | 3 | Code of first violation since clear, 0 when none |

## Verification
A wrong beat counter or a stale captured length shows at the ports as a spurious or absent early/missing-last flag on the final beat of the next burst, so each burst scenario checks the flags right after its last beat. A wrong shape decode appears one edge after the address handshake, and a broken sticky register shows as a flag or code that changes without a clear, which the bench exposes by chaining bursts between clears and expecting the first code to persist.

// File: rtl/burst_shape_monitor.sv
module burst_shape_monitor #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [7:0]        aw_len,
  input  logic [2:0]        aw_size,
  input  logic [1:0]        aw_kind,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  output logic [5:0]        err_vec,
  output logic [2:0]        err_code
);
  localparam logic [2:0] MAX_SZ = 3'($clog2(DATA_W/8));
  localparam logic [1:0] K_INCR = 2'd1;
  localparam logic [1:0] K_WRAP = 2'd2;

  logic       active;
  logic [7:0] beat_idx;
  logic [7:0] len_q;

  wire take_aw = aw_valid & aw_ready & ~active;
  wire beat    = active & w_valid & w_ready;

  wire [ADDR_W-1:0] lane_mask = (ADDR_W'(1) << aw_size) - ADDR_W'(1);
  wire [15:0] span   = 16'(({8'd0, aw_len} + 16'd1) << aw_size);
  wire [11:0] page_lo = aw_addr[11:0] & ~lane_mask[11:0];
  wire [16:0] end_off = {5'd0, page_lo} + {1'b0, span};

  wire size_bad   = aw_size > MAX_SZ;
  wire page_cross = (aw_kind == K_INCR) && (end_off > 17'd4096);
  wire wrap_len   = (aw_kind == K_WRAP) &&
                    !(aw_len == 8'd1 || aw_len == 8'd3 || aw_len == 8'd7 || aw_len == 8'd15);
  wire wrap_algn  = (aw_kind == K_WRAP) && ((aw_addr & lane_mask) != '0);

  wire at_end       = beat_idx == len_q;
  wire last_early   = beat & w_last & ~at_end;
  wire last_missing = beat & ~w_last & at_end;
  wire burst_done   = beat & (w_last | at_end);

  wire [5:0] new_bits = {last_missing, last_early,
                         take_aw & wrap_algn, take_aw & wrap_len,
                         take_aw & page_cross, take_aw & size_bad};

  logic [2:0] new_code;
  always_comb begin
    new_code = 3'd0;
    for (int i = 5; i >= 0; i--)
      if (new_bits[i]) new_code = 3'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat_idx <= '0;
      len_q    <= '0;
    end else if (take_aw) begin
      active   <= 1'b1;
      beat_idx <= '0;
      len_q    <= aw_len;
    end else if (burst_done) begin
      active   <= 1'b0;
    end else if (beat) begin
      beat_idx <= beat_idx + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_vec  <= '0;
      err_code <= '0;
    end else begin
      err_vec <= err_vec | new_bits;
      if (err_code == 3'd0) err_code <= new_code;
    end
  end
endmodule

module burst_shape_monitor_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [2:0]        aw_size,
  input logic [1:0]        aw_kind,
  input logic              w_valid,
  input logic              w_ready,
  input logic              active,
  input logic [5:0]        err_vec,
  input logic [2:0]        err_code
);
  localparam logic [2:0] MAX_SZ = 3'($clog2(DATA_W/8));
  wire hs = aw_valid & aw_ready & ~active;
  wire [ADDR_W-1:0] m = (ADDR_W'(1) << aw_size) - ADDR_W'(1);

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err_vec & $past(err_vec)) == $past(err_vec)));
  assert_code_tracks_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 3'd0) == (err_vec == 6'd0));
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_vec == 6'd0 && err_code == 3'd0));
  assert_size_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && aw_size > MAX_SZ && !clr) |=> err_vec[0]);
  assert_wrap_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && aw_kind == 2'd2 && (aw_addr & m) != '0 && !clr) |=> err_vec[3]);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(w_valid && w_ready) && !hs && !clr) |=> $stable(err_vec));
endmodule

bind burst_shape_monitor burst_shape_monitor_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .aw_addr(aw_addr), .aw_size(aw_size), .aw_kind(aw_kind), .w_valid(w_valid),
  .w_ready(w_ready), .active(active), .err_vec(err_vec), .err_code(err_code));

// File: tb/burst_shape_monitor_bench.sv
module burst_shape_monitor_bench;
  logic        clk = 0, rst_n = 0, clr = 0;
  logic        aw_valid = 0, aw_ready = 0;
  logic [31:0] aw_addr = 0;
  logic [7:0]  aw_len = 0;
  logic [2:0]  aw_size = 0;
  logic [1:0]  aw_kind = 0;
  logic        w_valid = 0, w_ready = 0, w_last = 0;
  logic [5:0]  err_vec;
  logic [2:0]  err_code;

  always #5 clk = ~clk;

  burst_shape_monitor #(.ADDR_W(32), .DATA_W(64)) u_burst_shape_monitor (.*);

  typedef struct { logic [5:0] v; logic [2:0] c; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [5:0] m_vec = 0;
  logic [2:0] m_code = 0;

  function automatic void expect_bits(input logic [5:0] b, input string tag);
    exp_t e;
    if (m_code == 0)
      for (int i = 5; i >= 0; i--) if (b[i]) m_code = 3'(i + 1);
    m_vec |= b;
    e.v = m_vec; e.c = m_code; e.tag = tag;
    sb.push_back(e);
  endfunction

  initial forever begin
    exp_t e;
    wait (sb.size() != 0);
    #1;
    e = sb.pop_front();
    checks++;
    if (err_vec !== e.v || err_code !== e.c) begin
      fails++;
      $display("FAIL %s: vec=%b code=%0d expected vec=%b code=%0d",
               e.tag, err_vec, err_code, e.v, e.c);
    end
  end

  task automatic do_clear(input string tag);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    m_vec = 0; m_code = 0;
    expect_bits(6'd0, tag);
  endtask

  task automatic run(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                     input logic [1:0] k, input int nbeats, input int last_at,
                     input bit stall, input logic [5:0] b, input string tag);
    @(negedge clk);
    aw_valid = 1; aw_ready = 1; aw_addr = a; aw_len = l; aw_size = s; aw_kind = k;
    @(negedge clk);
    aw_valid = 0; aw_ready = 0;
    for (int i = 0; i < nbeats; i++) begin
      if (stall) begin
        w_valid = 1; w_ready = 0; w_last = 1;
        @(negedge clk);
        w_valid = 0; w_ready = 1;
        @(negedge clk);
      end
      w_valid = 1; w_ready = 1; w_last = (i == last_at);
      @(negedge clk);
      w_valid = 0; w_ready = 0; w_last = 0;
    end
    expect_bits(b, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_bits(6'd0, "R1 reset state");
    run(32'h1000, 8'd3, 3'd3, 2'd1, 4, 3, 0, 6'd0, "R9 legal incr 4 beats");
    run(32'h2000, 8'd2, 3'd3, 2'd1, 3, 2, 0, 6'd0, "R9 legal but unintended length");
    run(32'h0, 8'd0, 3'd4, 2'd1, 1, 0, 0, 6'b000001, "R2 oversize beat");
    do_clear("R11 clear after size error");
    run(32'hFC0, 8'd7, 3'd3, 2'd1, 8, 7, 0, 6'd0, "R3 ends exactly on page edge");
    run(32'hFC8, 8'd7, 3'd3, 2'd1, 8, 7, 0, 6'b000010, "R3 crosses page");
    do_clear("R11 clear after page error");
    run(32'h100, 8'd2, 3'd3, 2'd2, 3, 2, 0, 6'b000100, "R4 wrap length 3");
    do_clear("R11 clear");
    run(32'h102, 8'd3, 3'd2, 2'd2, 4, 3, 0, 6'b001000, "R5 wrap misaligned");
    do_clear("R11 clear");
    run(32'h40, 8'd15, 3'd3, 2'd2, 16, 15, 0, 6'd0, "R4 R5 legal wrap 16");
    run(32'h300, 8'd3, 3'd3, 2'd1, 2, 1, 0, 6'b010000, "R6 early last");
    do_clear("R11 clear");
    run(32'h400, 8'd3, 3'd3, 2'd1, 4, 99, 0, 6'b100000, "R7 missing last");
    do_clear("R11 clear");
    run(32'h500, 8'd2, 3'd2, 2'd1, 3, 2, 1, 6'd0, "R8 stalled beats ignored");
    run(32'h0, 8'd0, 3'd5, 2'd0, 1, 0, 0, 6'b000001, "R10 first error size");
    run(32'h600, 8'd3, 3'd3, 2'd1, 3, 1, 0, 6'b010000, "R10 code stays first");
    do_clear("R11 clear");
    run(32'h101, 8'd2, 3'd1, 2'd2, 3, 2, 0, 6'b001100, "R10 lowest of simultaneous");
    run(32'h700, 8'd1, 3'd3, 2'd1, 2, 1, 0, 6'd0, "R12 legal burst keeps sticky");
    do_clear("R11 final clear");
    wait (sb.size() == 0);
    #5;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule